// File: doc/BRIEF.md
# Nine-bit SPI panel command writer

This block sends register commands to a display controller over a write-only serial link made of an active-low chip select, a serial clock and one data line. A host raises a one-cycle start strobe together with a command byte, a parameter count and a parameter value. The block frames the whole command as one chip-select transaction. It shifts out a 9-bit command word, then up to two 9-bit data words, and reports its progress on `busy` and `done`.

Every serial word carries a flag in its top bit. The flag is 0 for the command and 1 for a parameter byte, and the byte itself follows in the eight lower bits. The serial clock runs in SPI mode 3: it idles high, data changes while the clock is low, and the controller samples on the rising edge. The parameter `HALF_DIV` sets how many system clocks make up each half of a serial clock period.

Top module: `panel_cmd_spi`

## Requirements
- R1: Each serial word is 9 bits, sent most significant bit first. Bit 8 is 0 for the command word and 1 for a data word. Bits 7..0 carry the byte.
- R2: A frame is the command word followed by `min(paramCount,2)` data words. With two data words, `paramValue[15:8]` goes first and `paramValue[7:0]` second. With one data word, it carries `paramValue[7:0]`. A count of 3 behaves as 2.
- R3: Each bit holds `mosi` for `HALF_DIV` cycles with `sclk` low and then `HALF_DIV` cycles with `sclk` high. `mosi` changes inside a transaction only on the cycle where `sclk` goes low.
- R4: `csN` falls on the cycle after start is accepted. It stays low, with `sclk` high and the first bit on `mosi`, for `HALF_DIV` cycles before the first low phase. It rises right after the high phase of the last bit.
- R5: `sclk` is never low while `csN` is high. `csN` stays high for at least `2*HALF_DIV` cycles between transactions.
- R6: `busy` rises on the cycle after start is accepted. `done` is a one-cycle pulse in the first cycle after `csN` rises. `busy` stays high for the following `2*HALF_DIV` cycles of chip-select high time and then falls.
- R7: A start strobe that arrives while `busy` is high is ignored. The frame in progress and its timing are unchanged.
- R8: After reset, `busy`=0, `done`=0, `csN`=1, `sclk`=1 and `mosi`=0. `mosi` is 0 whenever `csN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startI | input | 1 | Start strobe, accepted only while idle |
| cmdByte | input | 8 | Command byte |
| paramCount | input | 2 | Number of parameter bytes (0..2, 3 acts as 2) |
| paramValue | input | 16 | Parameter value |
| busy | output | 1 | High from the cycle after acceptance until the guard time ends |
| done | output | 1 | One-cycle completion pulse |
| csN | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |

## Verification
Every output is registered or decoded from registered state, so each result appears one cycle after the edge that causes it. `csN` and `busy` change one cycle after acceptance. `sclk` and `mosi` then follow a fixed pattern: `HALF_DIV` cycles of lead-in, then `2*HALF_DIV` cycles per bit. `done` appears one cycle after the last high phase, and `busy` falls `2*HALF_DIV` cycles after that. The bench's model turns each accepted start into a queue holding one expected output tuple per cycle. At every rising edge it pops the entry due for the coming cycle. It compares all five outputs at the falling edge, so each check falls in the exact cycle where the result is due.

// File: rtl/panel_cmd_pkg.sv
package panel_cmd_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_LOW,
    PH_HIGH,
    PH_GUARD
  } phase_e;

  typedef struct packed {
    logic load;   // capture a new frame
    logic shift;  // advance to the next bit
    logic drive;  // chip select active: present the shifter MSB
  } dp_strobe_t;
endpackage

// File: rtl/panel_cmd_ctrl.sv
module panel_cmd_ctrl
  import panel_cmd_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startI,
  input  logic       lastBit,
  output dp_strobe_t strobe,
  output logic       csN,
  output logic       sclk,
  output logic       busy,
  output logic       done
);
  localparam int DIV_W = $clog2(2 * HALF_DIV + 1);
  localparam logic [DIV_W-1:0] HALF_LOAD  = DIV_W'(HALF_DIV - 1);
  localparam logic [DIV_W-1:0] GUARD_LOAD = DIV_W'(2 * HALF_DIV - 1);

  phase_e           phase, phaseNext;
  logic [DIV_W-1:0] divCnt, divNext;
  logic             doneNext;
  logic             tick;

  assign tick = (divCnt == '0);

  always_comb begin
    phaseNext    = phase;
    divNext      = tick ? divCnt : divCnt - 1'b1;
    doneNext     = 1'b0;
    strobe.load  = 1'b0;
    strobe.shift = 1'b0;
    strobe.drive = (phase == PH_LEAD) || (phase == PH_LOW) || (phase == PH_HIGH);
    case (phase)
      PH_IDLE: begin
        if (startI) begin
          phaseNext   = PH_LEAD;
          divNext     = HALF_LOAD;
          strobe.load = 1'b1;
        end
      end
      PH_LEAD: begin
        if (tick) begin
          phaseNext = PH_LOW;
          divNext   = HALF_LOAD;
        end
      end
      PH_LOW: begin
        if (tick) begin
          phaseNext = PH_HIGH;
          divNext   = HALF_LOAD;
        end
      end
      PH_HIGH: begin
        if (tick) begin
          if (lastBit) begin
            phaseNext = PH_GUARD;
            divNext   = GUARD_LOAD;
            doneNext  = 1'b1;
          end else begin
            phaseNext    = PH_LOW;
            divNext      = HALF_LOAD;
            strobe.shift = 1'b1;
          end
        end
      end
      PH_GUARD: begin
        if (tick) phaseNext = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      divCnt <= '0;
      done   <= 1'b0;
    end else begin
      phase  <= phaseNext;
      divCnt <= divNext;
      done   <= doneNext;
    end
  end

  assign csN  = !((phase == PH_LEAD) || (phase == PH_LOW) || (phase == PH_HIGH));
  assign sclk = (phase != PH_LOW);
  assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/panel_cmd_dp.sv
module panel_cmd_dp
  import panel_cmd_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int MAX_PARAMS = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dp_strobe_t                     strobe,
  input  logic [BYTE_W-1:0]              cmdByte,
  input  logic [$clog2(MAX_PARAMS+1)-1:0] paramCount,
  input  logic [BYTE_W*MAX_PARAMS-1:0]   paramValue,
  output logic                           mosi,
  output logic                           lastBit
);
  localparam int WORD_W  = BYTE_W + 1;
  localparam int FRAME_W = WORD_W * (MAX_PARAMS + 1);
  localparam int BITS_W  = $clog2(FRAME_W);

  logic [FRAME_W-1:0] frame, shreg;
  logic [BITS_W-1:0]  bitsInit, bitsLeft;
  int                 nUsed;

  always_comb begin
    nUsed = (int'(paramCount) > MAX_PARAMS) ? MAX_PARAMS : int'(paramCount);
    frame = '0;
    frame[FRAME_W-1 -: WORD_W] = {1'b0, cmdByte};
    for (int i = 0; i < MAX_PARAMS; i++) begin
      if (i < nUsed)
        frame[FRAME_W-1-WORD_W*(i+1) -: WORD_W] =
          {1'b1, paramValue[(nUsed-1-i)*BYTE_W +: BYTE_W]};
    end
    bitsInit = BITS_W'(WORD_W * (nUsed + 1) - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg    <= '0;
      bitsLeft <= '0;
    end else if (strobe.load) begin
      shreg    <= frame;
      bitsLeft <= bitsInit;
    end else if (strobe.shift) begin
      shreg    <= {shreg[FRAME_W-2:0], 1'b0};
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

  assign mosi    = strobe.drive & shreg[FRAME_W-1];
  assign lastBit = (bitsLeft == '0);
endmodule

// File: rtl/panel_cmd_spi.sv
module panel_cmd_spi
  import panel_cmd_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int BYTE_W     = 8,
  parameter int MAX_PARAMS = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            startI,
  input  logic [BYTE_W-1:0]               cmdByte,
  input  logic [$clog2(MAX_PARAMS+1)-1:0] paramCount,
  input  logic [BYTE_W*MAX_PARAMS-1:0]    paramValue,
  output logic                            busy,
  output logic                            done,
  output logic                            csN,
  output logic                            sclk,
  output logic                            mosi
);
  dp_strobe_t strobe;
  logic       lastBit;

  panel_cmd_ctrl #(.HALF_DIV(HALF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .startI(startI), .lastBit(lastBit),
    .strobe(strobe), .csN(csN), .sclk(sclk), .busy(busy), .done(done)
  );

  panel_cmd_dp #(.BYTE_W(BYTE_W), .MAX_PARAMS(MAX_PARAMS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdByte(cmdByte),
    .paramCount(paramCount), .paramValue(paramValue),
    .mosi(mosi), .lastBit(lastBit)
  );
endmodule

// File: rtl/panel_cmd_spi_chk.sv
module panel_cmd_spi_chk #(
  parameter int HALF_DIV   = 2,
  parameter int BYTE_W     = 8,
  parameter int MAX_PARAMS = 2
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            startI,
  input logic [BYTE_W-1:0]               cmdByte,
  input logic [$clog2(MAX_PARAMS+1)-1:0] paramCount,
  input logic [BYTE_W*MAX_PARAMS-1:0]    paramValue,
  input logic                            busy,
  input logic                            done,
  input logic                            csN,
  input logic                            sclk,
  input logic                            mosi
);
  localparam int RUN_W = $clog2(2 * HALF_DIV + 2);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(2 * HALF_DIV + 1);

  logic [RUN_W-1:0] hiRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hiRun <= RUN_MAX;
    else if (!csN) hiRun <= '0;
    else if (hiRun != RUN_MAX) hiRun <= hiRun + 1'b1;
  end

  assert_clk_idle_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk);

  assert_cs_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (hiRun >= RUN_W'(2 * HALF_DIV)));

  assert_done_after_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && !$past(csN)));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_from_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startI));

  assert_cs_only_when_idle_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> $past(startI && !busy));

  assert_data_moves_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN) && !$stable(mosi)) |-> !sclk);

  assert_quiet_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !mosi);
endmodule

bind panel_cmd_spi panel_cmd_spi_chk #(
  .HALF_DIV(HALF_DIV), .BYTE_W(BYTE_W), .MAX_PARAMS(MAX_PARAMS)
) u_chk (.*);

// File: tb/panel_cmd_spi_bench.sv
module panel_cmd_spi_bench;
  localparam int H = 2;
  localparam logic [4:0] IDLE_T = 5'b00110; // {busy,done,csN,sclk,mosi}

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startI = 1'b0;
  logic [7:0]  cmdByte = '0;
  logic [1:0]  paramCount = '0;
  logic [15:0] paramValue = '0;
  logic        busy, done, csN, sclk, mosi;

  int total = 0;
  int bad = 0;
  logic ignWin = 1'b0;
  logic checking = 1'b0;

  always #2 clk = ~clk;

  panel_cmd_spi #(.HALF_DIV(H)) u_panel_cmd_spi (
    .clk(clk), .rstN(rstN), .startI(startI), .cmdByte(cmdByte),
    .paramCount(paramCount), .paramValue(paramValue),
    .busy(busy), .done(done), .csN(csN), .sclk(sclk), .mosi(mosi)
  );

  logic [4:0] expQ[$];
  logic [4:0] expCur = IDLE_T;

  // Reference: one expected tuple per cycle after an accepted start (R1, R2, R3, R4, R6)
  task automatic buildSeq(input logic [7:0] c, input int n, input logic [15:0] v);
    logic [8:0] words[$];
    int k;
    k = (n > 2) ? 2 : n;
    words.push_back({1'b0, c});
    if (k == 2) begin
      words.push_back({1'b1, v[15:8]});
      words.push_back({1'b1, v[7:0]});
    end else if (k == 1) begin
      words.push_back({1'b1, v[7:0]});
    end
    for (int i = 0; i < H; i++) expQ.push_back({4'b1001, words[0][8]});
    foreach (words[w]) begin
      for (int b = 8; b >= 0; b--) begin
        for (int i = 0; i < H; i++) expQ.push_back({4'b1000, words[w][b]});
        for (int i = 0; i < H; i++) expQ.push_back({4'b1001, words[w][b]});
      end
    end
    for (int i = 0; i < 2 * H; i++) expQ.push_back({1'b1, (i == 0), 3'b110});
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expQ.delete();
      expCur = IDLE_T;
    end else begin
      if (!expCur[4] && startI) buildSeq(cmdByte, int'(paramCount), paramValue);
      if (expQ.size() > 0) expCur = expQ.pop_front();
      else expCur = IDLE_T;
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      logic [4:0] act;
      act = {busy, done, csN, sclk, mosi};
      total++;
      if (act !== expCur) begin
        bad++;
        if (act[0] !== expCur[0])
          $display("FAIL %s mosi (R1,R2,R8) actual=%b expected=%b", ignWin ? "R7" : "", act[0], expCur[0]);
        if (act[1] !== expCur[1])
          $display("FAIL %s sclk (R3,R5) actual=%b expected=%b", ignWin ? "R7" : "", act[1], expCur[1]);
        if (act[2] !== expCur[2])
          $display("FAIL %s csN (R4,R5) actual=%b expected=%b", ignWin ? "R7" : "", act[2], expCur[2]);
        if (act[4:3] !== expCur[4:3])
          $display("FAIL %s busy/done (R6) actual=%b expected=%b", ignWin ? "R7" : "", act[4:3], expCur[4:3]);
      end
    end
  end

  task automatic send(input logic [7:0] c, input logic [1:0] n, input logic [15:0] v);
    @(negedge clk);
    while (busy) @(negedge clk);
    startI = 1'b1; cmdByte = c; paramCount = n; paramValue = v;
    @(negedge clk);
    startI = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: outputs in reset
    total++;
    if ({busy, done, csN, sclk, mosi} !== IDLE_T) begin
      bad++;
      $display("FAIL R8 reset actual=%b expected=%b", {busy, done, csN, sclk, mosi}, IDLE_T);
    end
    rstN = 1'b1;
    checking = 1'b1;
    repeat (2) @(negedge clk);

    send(8'h00, 2'd0, 16'h0000); waitIdle();      // R1 command-only frame
    send(8'hB0, 2'd1, 16'hAB17); waitIdle();      // R2 one byte: low byte
    send(8'hB8, 2'd2, 16'hFFF9); waitIdle();      // R2 two bytes high first
    send(8'hFF, 2'd3, 16'h00FF); waitIdle();      // R2 count 3 acts as 2
    send(8'h5A, 2'd2, 16'hA55A); waitIdle();      // R3 alternating pattern

    // R7: starts during a transfer are ignored
    send(8'hC3, 2'd2, 16'h2040);
    repeat (10) @(negedge clk);
    ignWin = 1'b1;
    startI = 1'b1; cmdByte = 8'h29; paramCount = 2'd0; paramValue = 16'hFFFF;
    repeat (5) @(negedge clk);
    startI = 1'b0;
    waitIdle();
    ignWin = 1'b0;

    // R5: start held high, back-to-back frames
    startI = 1'b1; cmdByte = 8'h11; paramCount = 2'd1; paramValue = 16'h0001;
    repeat (3 * (H + 36 * H + 2 * H + 2)) @(negedge clk);
    startI = 1'b0;
    waitIdle();

    checking = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired (R6) actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule